// File: doc/BRIEF.md
# Nibble-Wide Table Lookup Pointer

This block lets a datapath that moves four bits at a time fetch eight-bit constants held in program memory. A twelve-bit pointer is assembled from three four-bit field writes, each driven from the same four-bit write bus. Two kinds of read then fetch the byte the pointer names. The low read returns its lower nibble and leaves the pointer where it is. The high read returns its upper nibble and steps the pointer forward by one. Issuing low/high pairs therefore walks through a table of bytes.

The pointer goes straight out as the program-memory address. The memory answers with the byte one clock after it samples that address. A read that is accepted in one cycle yields its nibble, flagged by a one-cycle valid pulse, in the next cycle. While that result is showing, new read requests are dropped.

Top module: `nibble_table_ptr`

## Requirements
- R1: After reset the pointer (romAddr) is 000h, nibValid is 0 and nibOut is 0.
- R2: wrField bit 0 loads pointer bits 3..0, bit 1 loads bits 7..4 and bit 2 loads bits 11..8 from wrData at the clock edge. Pointer bits whose field strobe is low keep their value.
- R3: Several field strobes raised in the same cycle all load wrData into their slices at that edge.
- R4: A low read (rdLow) accepted in cycle t gives nibValid=1 for exactly cycle t+1, with nibOut equal to bits 3..0 of the byte at the address shown in cycle t. The pointer is unchanged.
- R5: A high read (rdHigh) accepted in cycle t gives nibValid=1 in cycle t+1, with nibOut equal to bits 7..4 of the byte at the cycle-t address. From cycle t+1 the pointer is one greater.
- R6: The pointer increment wraps from FFFh to 000h.
- R7: A read request in a cycle where nibValid is 1 is ignored: there is no valid pulse in the next cycle and the pointer does not move.
- R8: If rdLow and rdHigh are both high in an accepted cycle, the block performs a high read.
- R9: A field write in the same cycle as an accepted high read loads its slice from wrData. The other slices take the incremented pointer value.
- R10: With the pointer loaded as 777h and the byte there equal to 56h, a low read yields 6h and the following high read yields 5h.
- R11: nibOut is 0 whenever nibValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 4 | Nibble written into a pointer field |
| wrField | input | 3 | Field write strobes: bit 0 low, bit 1 middle, bit 2 high |
| rdLow | input | 1 | Request a low-nibble read |
| rdHigh | input | 1 | Request a high-nibble read with post-increment |
| romAddr | output | 12 | Program-memory address (the pointer) |
| romByte | input | 8 | Byte returned by memory one cycle after the address |
| nibOut | output | 4 | Read result |
| nibValid | output | 1 | One-cycle pulse marking nibOut valid |

## Verification
The bench goes after the following corner cases:
- **Field sweep.** Each field is swept through all sixteen values. A slice decode that touched a neighbour would corrupt the untouched bits.
- **Table walk and wrap.** A walk of low/high pairs across a table checks the nibble choice. A pair that crosses FFFh checks the wrap. A design that incremented on the low read, or that picked nibbles from the new address, would show skipped or repeated bytes.
- **Read while busy.** Back-to-back requests must be dropped. A design without that guard would double-increment the pointer.
- **Overlapping operations.** Both read strobes together, and a write during a high read, must resolve as R8 and R9 specify. Getting either wrong gives the wrong nibble or a lost increment.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  localparam int NIB_W  = 4;
  localparam int FIELDS = 3;
  localparam int PTR_W  = NIB_W * FIELDS;
  localparam int BYTE_W = 2 * NIB_W;

  typedef struct packed {
    logic [FIELDS-1:0] wrField;
    logic              incr;
  } ptrCmd_t;
endpackage

// File: rtl/tlp_ctrl.sv
module tlp_ctrl
  import tlp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FIELDS-1:0] wrField,
  input  logic              rdLow,
  input  logic              rdHigh,
  output ptrCmd_t           cmd,
  output logic              pending,
  output logic              selHigh
);
  logic accept;

  // a read is taken only when no earlier read is still presenting its result
  assign accept = (rdLow | rdHigh) & ~pending;

  always_comb begin
    cmd.wrField = wrField;
    cmd.incr    = accept & rdHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      selHigh <= 1'b0;
    end else begin
      pending <= accept;
      if (accept) selHigh <= rdHigh;
    end
  end
endmodule

// File: rtl/tlp_dpath.sv
module tlp_dpath
  import tlp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ptrCmd_t           cmd,
  input  logic [NIB_W-1:0]  wrData,
  input  logic              pending,
  input  logic              selHigh,
  input  logic [BYTE_W-1:0] romByte,
  output logic [PTR_W-1:0]  ptr,
  output logic [NIB_W-1:0]  nibOut
);
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] nextPtr;

  assign stepped = cmd.incr ? ptr + PTR_W'(1) : ptr;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    assign nextPtr[g*NIB_W +: NIB_W] =
      cmd.wrField[g] ? wrData : stepped[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else       ptr <= nextPtr;
  end

  always_comb begin
    if (!pending)     nibOut = '0;
    else if (selHigh) nibOut = romByte[BYTE_W-1:NIB_W];
    else              nibOut = romByte[NIB_W-1:0];
  end
endmodule

// File: rtl/nibble_table_ptr.sv
module nibble_table_ptr
  import tlp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  wrData,
  input  logic [FIELDS-1:0] wrField,
  input  logic              rdLow,
  input  logic              rdHigh,
  output logic [PTR_W-1:0]  romAddr,
  input  logic [BYTE_W-1:0] romByte,
  output logic [NIB_W-1:0]  nibOut,
  output logic              nibValid
);
  ptrCmd_t cmd;
  logic    pending;
  logic    selHigh;

  tlp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrField(wrField), .rdLow(rdLow), .rdHigh(rdHigh),
    .cmd(cmd), .pending(pending), .selHigh(selHigh)
  );

  tlp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData), .pending(pending),
    .selHigh(selHigh), .romByte(romByte), .ptr(romAddr), .nibOut(nibOut)
  );

  assign nibValid = pending;
endmodule

// File: rtl/nibble_table_ptr_chk.sv
module nibble_table_ptr_chk
  import tlp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NIB_W-1:0]  wrData,
  input logic [FIELDS-1:0] wrField,
  input logic              rdLow,
  input logic              rdHigh,
  input logic [PTR_W-1:0]  romAddr,
  input logic [NIB_W-1:0]  nibOut,
  input logic              nibValid
);
  assert_low_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrField[0] |=> romAddr[NIB_W-1:0] == $past(wrData));

  assert_low_read_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdLow && !rdHigh && !nibValid && wrField == '0) |=> nibValid && $stable(romAddr));

  assert_high_read_steps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdHigh && !nibValid && wrField == '0) |=> nibValid && romAddr == PTR_W'($past(romAddr) + PTR_W'(1)));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    nibValid |=> !nibValid);

  assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (nibValid && wrField == '0) |=> $stable(romAddr));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !nibValid |-> nibOut == '0);
endmodule

bind nibble_table_ptr nibble_table_ptr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrData(wrData), .wrField(wrField), .rdLow(rdLow),
  .rdHigh(rdHigh), .romAddr(romAddr), .nibOut(nibOut), .nibValid(nibValid)
);

// File: tb/nibble_table_ptr_bench.sv
module nibble_table_ptr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  wrData = '0;
  logic [2:0]  wrField = '0;
  logic        rdLow = 1'b0;
  logic        rdHigh = 1'b0;
  logic [11:0] romAddr;
  logic [7:0]  romByte = '0;
  logic [3:0]  nibOut;
  logic        nibValid;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_table_ptr u_nibble_table_ptr (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrField(wrField), .rdLow(rdLow),
    .rdHigh(rdHigh), .romAddr(romAddr), .romByte(romByte), .nibOut(nibOut),
    .nibValid(nibValid)
  );

  function automatic logic [7:0] romFn(input logic [11:0] a);
    if (a == 12'h777) return 8'h56;
    return 8'(a[7:0] * 8'd13 + {4'h0, a[11:8]} + 8'h29);
  endfunction

  // synchronous program memory model: one-cycle byte return
  always_ff @(posedge clk) romByte <= romFn(romAddr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeField(input logic [2:0] f, input logic [3:0] d);
    wrField = f; wrData = d;
    @(negedge clk);
    wrField = '0;
  endtask

  task automatic loadPtr(input logic [11:0] v);
    writeField(3'b111, v[3:0]);
    writeField(3'b110, v[7:4]);
    writeField(3'b100, v[11:8]);
  endtask

  // issue a read, check nibble, address, then the single-cycle pulse
  task automatic doRead(input bit hi, input string req);
    logic [11:0] a;
    logic [7:0]  b;
    logic [11:0] expAddr;
    a = romAddr;
    b = romFn(a);
    expAddr = hi ? a + 12'd1 : a;
    rdHigh = hi; rdLow = !hi;
    @(negedge clk);
    rdHigh = 1'b0; rdLow = 1'b0;
    check(nibValid === 1'b1, req, int'(nibValid), 1);
    check(nibOut === (hi ? b[7:4] : b[3:0]), req, int'(nibOut), int'(hi ? b[7:4] : b[3:0]));
    check(romAddr === expAddr, req, int'(romAddr), int'(expAddr));
    @(negedge clk);
    check(nibValid === 1'b0 && nibOut === 4'h0, {req, "/R11"}, int'(nibOut), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(romAddr === 12'h000, "R1", int'(romAddr), 0);
    check(nibValid === 1'b0, "R1", int'(nibValid), 0);
    check(nibOut === 4'h0, "R1", int'(nibOut), 0);

    // R2 sweep each field through all values, others must hold
    loadPtr(12'h5A3);
    for (int f = 0; f < 3; f++) begin
      for (int v = 0; v < 16; v++) begin
        logic [11:0] exp;
        exp = 12'h5A3;
        exp[f*4 +: 4] = 4'(v);
        writeField(3'(1 << f), 4'(v));
        check(romAddr === exp, "R2", int'(romAddr), int'(exp));
        loadPtr(12'h5A3);
      end
    end

    // R3 simultaneous field writes
    writeField(3'b101, 4'hC);
    check(romAddr === 12'hCAC, "R3", int'(romAddr), 12'hCAC);

    // R10 worked example
    loadPtr(12'h777);
    doRead(1'b0, "R10");
    check(romAddr === 12'h777, "R10", int'(romAddr), 12'h777);
    doRead(1'b1, "R10");
    check(romAddr === 12'h778, "R10", int'(romAddr), 12'h778);

    // R4/R5 table walk of low/high pairs
    loadPtr(12'h3F0);
    for (int i = 0; i < 40; i++) begin
      doRead(1'b0, "R4");
      doRead(1'b1, "R5");
    end
    check(romAddr === 12'h418, "R5", int'(romAddr), 12'h418);

    // R6 wrap
    loadPtr(12'hFFE);
    for (int i = 0; i < 3; i++) begin
      doRead(1'b0, "R6");
      doRead(1'b1, "R6");
    end
    check(romAddr === 12'h001, "R6", int'(romAddr), 1);

    // R7 back-to-back requests: second ignored
    loadPtr(12'h240);
    rdHigh = 1'b1;
    @(negedge clk);
    check(nibValid === 1'b1 && nibOut === romFn(12'h240)[7:4], "R7",
          int'(nibOut), int'(romFn(12'h240)[7:4]));
    @(negedge clk);
    rdHigh = 1'b0;
    check(nibValid === 1'b0, "R7", int'(nibValid), 0);
    check(romAddr === 12'h241, "R7", int'(romAddr), 12'h241);

    // R8 both strobes: high read
    loadPtr(12'h123);
    rdHigh = 1'b1; rdLow = 1'b1;
    @(negedge clk);
    rdHigh = 1'b0; rdLow = 1'b0;
    check(nibOut === romFn(12'h123)[7:4], "R8", int'(nibOut), int'(romFn(12'h123)[7:4]));
    check(romAddr === 12'h124, "R8", int'(romAddr), 12'h124);
    @(negedge clk);

    // R9 write during high read: written slice wins, rest incremented
    loadPtr(12'h2FF);
    rdHigh = 1'b1; wrField = 3'b001; wrData = 4'h7;
    @(negedge clk);
    rdHigh = 1'b0; wrField = '0;
    check(nibOut === romFn(12'h2FF)[7:4], "R9", int'(nibOut), int'(romFn(12'h2FF)[7:4]));
    check(romAddr === 12'h307, "R9", int'(romAddr), 12'h307);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule